// File: doc/BRIEF.md
# Periodic Rate Generator with Seconds Tick and Square Wave

This block divides a 32.768 kHz reference, presented as a one-cycle clock enable, through a 15-stage binary counter. From that counter it derives three registered outputs. The first is a one-per-second update tick. The second is a periodic-event strobe at one of fifteen rates chosen by a 4-bit code. The third is a 50% square wave at the same rate.

A 7-bit control field carries both the rate code and a 3-bit time-base selector. The time-base selector changes how the two fastest codes are read. Two of its values hold the whole counter cleared, which stops every output.

The strobe feeds a flag register that lives outside this block. A gated copy of the strobe is provided for the interrupt path. Square-wave output has its own enable.

Top module: `periodic_rate_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `per_strobe`, `per_irq`, `sec_tick` and `sqw_out` are low, and the tick count restarts from zero.
- R2: For a rate code c = `ctrl_a[3:0]` from 3 to 15, `per_strobe` fires once every 2^(c-1) reference ticks. This gives 8192 Hz for c=3 down to 2 Hz for c=15.
- R3: With time-base field `ctrl_a[6:4]` = 010, codes 1 and 2 give periods of 2^7 and 2^8 ticks (256 Hz and 128 Hz).
- R4: With any running time-base value other than 010, codes 1 and 2 give periods of 1 and 2 ticks (32768 Hz and 16384 Hz).
- R5: Rate code 0 produces no strobe, and `sqw_out` stays low.
- R6: Time-base value 110 or 111 holds the tick count at zero and silences all outputs. After release, the first strobe comes exactly one full period of ticks later.
- R7: `per_strobe` is high for one clock, in the clock after the reference tick that completes a period, and never without such a tick.
- R8: `per_irq` equals `per_strobe` while `pie_en` is high and is low otherwise.
- R9: `sec_tick` pulses once every 2^15 reference ticks, when the count wraps to zero.
- R10: When `sqw_en` is high and the code is nonzero, `sqw_out` equals bit (e-1) of the running tick count, where 2^e is the period. For e=0 it equals bit 0. In all other cases it is low.
- R11: Changing the rate code while running does not clear the count. The new tap applies from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| ctrl_a | input | 7 | [3:0] rate code, [6:4] time-base selector |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic interrupt enable |
| per_strobe | output | 1 | Periodic flag set pulse |
| per_irq | output | 1 | Strobe gated by pie_en |
| sec_tick | output | 1 | Once-per-second update tick |
| sqw_out | output | 1 | Square wave at the selected rate |

## Verification
The hardest condition to reach is the alternate meaning of codes 1 and 2, because it only appears when the time-base field equals 010. The bench therefore sweeps every rate code under four time-base values. Before each combination it applies a hold, so that the first period after release is also measured.

A second hard case is the full-counter wrap behind the seconds tick, which needs 32768 ticks. One long run with a tick on every clock is devoted to it, and that run also counts the 2 Hz strobes.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int EW = 4;
  localparam logic [2:0] BASE_32K = 3'b010;

  // log2 of the period in reference ticks for a nonzero rate code
  function automatic logic [EW-1:0] tap_exp(input logic [3:0] code, input logic is_32k);
    logic [EW-1:0] e;
    if (code == 4'd0)                e = '0;
    else if (is_32k && code <= 4'd2) e = code + 4'd6;
    else                             e = code - 4'd1;
    return e;
  endfunction
endpackage

// File: rtl/rate_div_chain.sv
module rate_div_chain #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              tick,
  output logic [STAGES-1:0] cnt_next
);
  logic [STAGES-1:0] cnt_q;

  always_comb begin
    if (hold)      cnt_next = '0;
    else if (tick) cnt_next = cnt_q + 1'b1;
    else           cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0)); // R6
  AST_IDLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!hold && !tick) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/rate_tap_sel.sv
module rate_tap_sel
  import rate_gen_pkg::*;
(
  input  logic [6:0]    ctrl,
  output logic [EW-1:0] exp_sel,
  output logic          active,
  output logic          run
);
  logic [3:0] code;
  logic [2:0] base;

  always_comb begin
    code    = ctrl[3:0];
    base    = ctrl[6:4];
    run     = !(base[2] && base[1]);
    active  = (code != 4'd0);
    exp_sel = tap_exp(code, base == BASE_32K);
  end
endmodule

// File: rtl/rate_out_stage.sv
module rate_out_stage
  import rate_gen_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              active,
  input  logic [EW-1:0]     exp_sel,
  input  logic [STAGES-1:0] cnt_next,
  input  logic              sqw_en,
  input  logic              pie_en,
  output logic              strobe,
  output logic              irq,
  output logic              sec,
  output logic              sqw
);
  logic [STAGES-1:0] low_mask;
  logic [STAGES-1:0] bit_pick;
  logic [EW-1:0]     sqw_idx;
  logic              hit, half, strobe_d;

  assign sqw_idx = (exp_sel == '0) ? '0 : exp_sel - 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    assign low_mask[i] = (EW'(i) < exp_sel);
    assign bit_pick[i] = (EW'(i) == sqw_idx);
  end

  always_comb begin
    hit      = ((cnt_next & low_mask) == '0);
    half     = |(cnt_next & bit_pick);
    strobe_d = tick && run && active && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      irq    <= 1'b0;
      sec    <= 1'b0;
      sqw    <= 1'b0;
    end else begin
      strobe <= strobe_d;
      irq    <= strobe_d && pie_en;
      sec    <= tick && run && (cnt_next == '0);
      sqw    <= sqw_en && run && active && half;
    end
  end

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(tick && run && active)); // R7
  AST_SQW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sqw_en || !active || !run) |=> !sqw); // R10
  AST_SEC_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    sec |-> $past(tick && run)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !pie_en |=> !irq); // R8
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import rate_gen_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic [6:0] ctrl_a,
  input  logic       sqw_en,
  input  logic       pie_en,
  output logic       per_strobe,
  output logic       per_irq,
  output logic       sec_tick,
  output logic       sqw_out
);
  logic [EW-1:0]     exp_sel;
  logic              active, run;
  logic [STAGES-1:0] cnt_next;

  rate_tap_sel u_sel (
    .ctrl(ctrl_a), .exp_sel(exp_sel), .active(active), .run(run)
  );

  rate_div_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst(rst), .hold(!run), .tick(ref_tick), .cnt_next(cnt_next)
  );

  rate_out_stage #(.STAGES(STAGES)) u_out (
    .clk(clk), .rst(rst), .tick(ref_tick), .run(run), .active(active),
    .exp_sel(exp_sel), .cnt_next(cnt_next), .sqw_en(sqw_en), .pie_en(pie_en),
    .strobe(per_strobe), .irq(per_irq), .sec(sec_tick), .sqw(sqw_out)
  );

  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!per_strobe && !sec_tick)); // R6
endmodule

// File: tb/test_periodic_rate_gen.sv
module test_periodic_rate_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic [6:0] ctrl_a = 7'h60;
  logic       sqw_en = 1'b0;
  logic       pie_en = 1'b0;
  logic       per_strobe, per_irq, sec_tick, sqw_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [14:0] m_cnt = '0;
  logic [15:0] lfsr = 16'hACE1;
  string tag_force = "";
  int strobe_seen = 0;
  int sec_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_rate_gen i_periodic_rate_gen (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ctrl_a(ctrl_a),
    .sqw_en(sqw_en), .pie_en(pie_en), .per_strobe(per_strobe),
    .per_irq(per_irq), .sec_tick(sec_tick), .sqw_out(sqw_out)
  );

  function automatic int exp_of(input logic [3:0] c, input logic [2:0] d);
    if (c == 0) return 0;
    if (c <= 2 && d == 3'b010) return c + 6;
    return c - 1;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (ctrl %h cnt %0d)", req, act, expv, ctrl_a, m_cnt);
    end
  endtask

  // called just after a falling edge; applies tick, spans one rising edge
  task automatic cyc(input logic tk);
    logic [2:0] d;
    logic [3:0] c;
    logic run;
    logic [14:0] nxt;
    int e, idx;
    logic es, ei, ec, eq;
    string ts, tq;
    ref_tick = tk;
    d = ctrl_a[6:4];
    c = ctrl_a[3:0];
    run = !(d == 3'b110 || d == 3'b111);
    e = exp_of(c, d);
    idx = (e == 0) ? 0 : e - 1;
    nxt = run ? (tk ? m_cnt + 15'd1 : m_cnt) : 15'd0;
    es = tk && run && (c != 0) && ((int'(nxt) % (1 << e)) == 0);
    ei = es && pie_en;
    ec = tk && run && (nxt == 0);
    eq = sqw_en && run && (c != 0) && nxt[idx];
    if (tag_force != "")       begin ts = tag_force; tq = tag_force; end
    else if (!run)             begin ts = "R6"; tq = "R6"; end
    else if (c == 0)           begin ts = "R5"; tq = "R5"; end
    else if (c <= 2)           begin ts = (d == 3'b010) ? "R3" : "R4"; tq = "R10"; end
    else                       begin ts = "R2"; tq = "R10"; end
    @(posedge clk);
    @(negedge clk);
    m_cnt = nxt;
    check(ts, per_strobe, es);
    check("R8", per_irq, ei);
    check(run ? "R9" : "R6", sec_tick, ec);
    check(tq, sqw_out, eq);
    if (per_strobe) strobe_seen++;
    if (sec_tick) sec_seen++;
  endtask

  function automatic logic rnd_tick();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] | lfsr[1];
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] bases [4];
    bases = '{3'b000, 3'b001, 3'b010, 3'b101};
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", per_strobe, 1'b0);
    check("R1", sec_tick, 1'b0);
    check("R1", sqw_out, 1'b0);
    ctrl_a = 7'h03; sqw_en = 1'b1; pie_en = 1'b1;
    rst = 1'b0;
    m_cnt = '0;
    @(negedge clk);
    check("R1", per_strobe, 1'b0);
    check("R1", per_irq, 1'b0);
    m_cnt = '0;
    for (int i = 0; i < 40; i++) cyc(1'b1); // R1 first strobes from zero

    // sweep of time bases and rate codes, each preceded by a hold (R6)
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 16; c++) begin
        ctrl_a = {3'b110 | {2'b0, c[0]}, c[3:0]};
        cyc(1'b1);
        cyc(1'b0);
        ctrl_a = {bases[b], c[3:0]};
        sqw_en = (c != 7);
        pie_en = c[1];
        for (int k = 0; k < 300; k++) cyc(k < 160 ? 1'b1 : rnd_tick());
      end
    end

    // R9 and R2: one long run at code 15 with a tick every clock
    ctrl_a = 7'h6F;
    cyc(1'b1);
    ctrl_a = 7'h0F;
    sqw_en = 1'b1;
    strobe_seen = 0;
    sec_seen = 0;
    for (int k = 0; k < 65536; k++) cyc(1'b1);
    n_chk++;
    if (strobe_seen != 4) begin n_fail++; $display("FAIL R2: actual %0d expected 4 strobes", strobe_seen); end
    n_chk++;
    if (sec_seen != 2) begin n_fail++; $display("FAIL R9: actual %0d expected 2 seconds ticks", sec_seen); end

    // R11: rate changes while running, count not cleared
    tag_force = "R11";
    ctrl_a = 7'h23;
    for (int k = 0; k < 100; k++) cyc(1'b1);
    ctrl_a = 7'h25;
    for (int k = 0; k < 100; k++) cyc(rnd_tick());
    ctrl_a = 7'h21;
    for (int k = 0; k < 300; k++) cyc(1'b1);
    ctrl_a = 7'h02;
    for (int k = 0; k < 50; k++) cyc(1'b1);

    // R7: sparse ticks, strobe one clock wide
    tag_force = "R7";
    ctrl_a = 7'h03;
    strobe_seen = 0;
    for (int k = 0; k < 400; k++) cyc((k % 5) == 0);
    n_chk++;
    if (strobe_seen != 20) begin n_fail++; $display("FAIL R7: actual %0d expected 20 one-clock strobes", strobe_seen); end

    // R10: square wave disabled mid-run, R8: interrupt mask toggling
    tag_force = "";
    ctrl_a = 7'h04;
    for (int k = 0; k < 120; k++) begin
      sqw_en = (k % 40) < 20;
      pie_en = (k % 30) < 15;
      cyc(1'b1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule